// File: doc/BRIEF.md
# Transfer Descriptor Token Update Engine

This block sits in a USB host controller's descriptor execution path. Each time a bus transaction on a transfer descriptor ends, it gets three things: the descriptor's 32-bit control token, a one-hot result code and the number of bytes the transaction moved. One clock cycle later it returns the rewritten token, together with the descriptor's active and halted state, a retire strobe and interrupt requests.

The engine keeps the remaining byte count up to date and decides when the descriptor is finished. It also runs the consecutive-error counter and applies the halting rules. Error causes are not all treated alike. A transaction error uses up one retry. A buffer error is noted but costs no retry. A stall or babble halts the descriptor at once and does not touch the counter. A counter preset to zero means retries are unlimited. Fetching the descriptor, writing it back and scheduling are handled elsewhere.

Top module: `td_token_update`

## Requirements
- R1: Token fields are: bit 31 toggle, bits 30:16 remaining bytes, bit 15 interrupt-on-complete, bits 14:12 page index, bits 11:10 error counter, bit 7 active, bit 6 halted, bit 5 buffer-error flag, bit 4 babble flag, bit 3 transaction-error flag. The result code is one-hot: bit 0 success, bit 1 transaction error, bit 2 buffer error, bit 3 stall, bit 4 babble. The outputs are registered and `out_valid` is high exactly in the cycle after `upd_valid`.
- R2: On success, the remaining byte count drops by the bytes moved and saturates at zero. On any other result it is left unchanged.
- R3: On success, the descriptor retires when the new count is zero or when fewer bytes than `max_pkt` were moved. Retiring clears active, leaves halted clear and pulses `retire`. A descriptor whose count is already zero retires after its zero-length transaction.
- R4: On success the toggle bit flips when `toggle_from_td` is 1. In every other case it is left as it is.
- R5: `irq_complete` pulses only when a descriptor retires with interrupt-on-complete set.
- R6: A transaction error with a nonzero counter decrements the counter. If the counter is still nonzero afterwards, the descriptor stays active.
- R7: A transaction error that takes the counter from 1 to 0 clears active and sets halted and the transaction-error flag. In that case `irq_error` pulses only if `err_irq_en` is 1.
- R8: A transaction error with the counter at 0 changes nothing in the token, so retries are unlimited.
- R9: A buffer error sets the buffer-error flag and leaves the counter and active bit unchanged.
- R10: A stall or babble sets halted and clears active without changing the counter. Babble also sets the babble flag. `irq_error` follows `err_irq_en`.
- R11: An update on an inactive token returns the input token unchanged, and `retire`, `irq_complete` and `irq_error` stay low.
- R12: The page index is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | Update request for this cycle |
| tok_in | input | 32 | Current token |
| result | input | 5 | One-hot transaction result |
| bytes_moved | input | 15 | Bytes transferred by the transaction |
| max_pkt | input | 11 | Maximum packet length of the endpoint |
| toggle_from_td | input | 1 | Toggle is taken from the descriptor |
| err_irq_en | input | 1 | Error interrupt enable |
| tok_out | output | 32 | Updated token |
| out_valid | output | 1 | Updated token is presented |
| active_out | output | 1 | Descriptor still active |
| halted_out | output | 1 | Descriptor halted |
| retire | output | 1 | Descriptor completed successfully |
| irq_complete | output | 1 | Completion interrupt request |
| irq_error | output | 1 | Error interrupt request |

## Verification
The checker assumes three things about each update: exactly one result bit is set, the byte count is at most five 4 KB pages (0x5000), and the page index is at most 4. The directed scenarios build every token from legal field values and always drive a single result bit. Byte counts used include zero, an exact packet, a short packet and a multi-packet remainder. Error counters are driven at 0, 1, 2 and 3, and both settings of the interrupt enable are applied. That covers every branch of the counter and halt rules.

// File: rtl/td_tok_pkg.sv
package td_tok_pkg;
   localparam int TOK_W     = 32;
   localparam int TGL_B     = 31;
   localparam int BYTES_HI  = 30;
   localparam int BYTES_LO  = 16;
   localparam int BYTES_W   = BYTES_HI - BYTES_LO + 1;
   localparam int IOC_B     = 15;
   localparam int PAGE_HI   = 14;
   localparam int PAGE_LO   = 12;
   localparam int PAGE_W    = PAGE_HI - PAGE_LO + 1;
   localparam int CERR_HI   = 11;
   localparam int CERR_LO   = 10;
   localparam int CERR_W    = CERR_HI - CERR_LO + 1;
   localparam int ACT_B     = 7;
   localparam int HALT_B    = 6;
   localparam int BUFERR_B  = 5;
   localparam int BABBLE_B  = 4;
   localparam int XACTERR_B = 3;

   localparam int RES_W      = 5;
   localparam int RES_OK     = 0;
   localparam int RES_XACT   = 1;
   localparam int RES_BUF    = 2;
   localparam int RES_STALL  = 3;
   localparam int RES_BABBLE = 4;
endpackage

// File: rtl/td_bytecount.sv
module td_bytecount #(
   parameter int BYTES_W  = 15,
   parameter int MPL_W    = 11,
   parameter bit SATURATE = 1'b1
) (
   input  logic [BYTES_W-1:0] total,
   input  logic [BYTES_W-1:0] moved,
   input  logic [MPL_W-1:0]   max_pkt,
   output logic [BYTES_W-1:0] next_total,
   output logic               done
);
   localparam int PAD_W = BYTES_W - MPL_W;

   logic [BYTES_W-1:0] mpl_ext;
   logic               short_pkt;

   if (PAD_W > 0) begin : g_pad
      assign mpl_ext = {{PAD_W{1'b0}}, max_pkt};
   end else begin : g_nopad
      assign mpl_ext = max_pkt[BYTES_W-1:0];
   end

   if (SATURATE) begin : g_sat
      assign next_total = (moved >= total) ? '0 : (total - moved);
   end else begin : g_wrap
      assign next_total = total - moved;
   end

   assign short_pkt = (moved < mpl_ext);
   assign done      = (next_total == '0) || short_pkt;
endmodule

// File: rtl/td_errcount.sv
module td_errcount #(
   parameter int CERR_W = 2
) (
   input  logic [CERR_W-1:0] cerr,
   input  logic              is_xact,
   output logic [CERR_W-1:0] next_cerr,
   output logic              exhausted
);
   localparam logic [CERR_W-1:0] ONE = CERR_W'(1);

   logic counting;

   assign counting  = is_xact && (cerr != '0);
   assign next_cerr = counting ? (cerr - ONE) : cerr;
   assign exhausted = counting && (cerr == ONE);
endmodule

// File: rtl/td_token_update.sv
module td_token_update
   import td_tok_pkg::*;
#(
   parameter int MPL_W     = 11,
   parameter bit SATURATE  = 1'b1,
   parameter int MAX_BYTES = 20480,
   parameter int MAX_PAGE  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [TOK_W-1:0]  tok_in,
   input  logic [RES_W-1:0]  result,
   input  logic [BYTES_W-1:0] bytes_moved,
   input  logic [MPL_W-1:0]  max_pkt,
   input  logic              toggle_from_td,
   input  logic              err_irq_en,
   output logic [TOK_W-1:0]  tok_out,
   output logic              out_valid,
   output logic              active_out,
   output logic              halted_out,
   output logic              retire,
   output logic              irq_complete,
   output logic              irq_error
);
   if (MPL_W > BYTES_W) begin : g_bad_mpl
      $error("MPL_W must not exceed the byte-count width");
   end
   if (MAX_BYTES >= (1 << BYTES_W)) begin : g_bad_bytes
      $error("MAX_BYTES does not fit the byte-count field");
   end
   if (MAX_PAGE >= (1 << PAGE_W)) begin : g_bad_page
      $error("MAX_PAGE does not fit the page field");
   end

   logic [BYTES_W-1:0] bc_next;
   logic               bc_done;
   logic [CERR_W-1:0]  ec_next;
   logic               ec_exh;
   logic               live;
   logic [TOK_W-1:0]   nxt;
   logic               ret_d, irqc_d, irqe_d;

   td_bytecount #(
      .BYTES_W (BYTES_W),
      .MPL_W   (MPL_W),
      .SATURATE(SATURATE)
   ) u_bytes (
      .total     (tok_in[BYTES_HI:BYTES_LO]),
      .moved     (bytes_moved),
      .max_pkt   (max_pkt),
      .next_total(bc_next),
      .done      (bc_done)
   );

   td_errcount #(
      .CERR_W(CERR_W)
   ) u_err (
      .cerr     (tok_in[CERR_HI:CERR_LO]),
      .is_xact  (result[RES_XACT]),
      .next_cerr(ec_next),
      .exhausted(ec_exh)
   );

   assign live = upd_valid && tok_in[ACT_B];

   always_comb begin
      nxt    = tok_in;
      ret_d  = 1'b0;
      irqc_d = 1'b0;
      irqe_d = 1'b0;
      if (live) begin
         if (result[RES_OK]) begin
            nxt[BYTES_HI:BYTES_LO] = bc_next;
            if (toggle_from_td) nxt[TGL_B] = ~tok_in[TGL_B];
            if (bc_done) begin
               nxt[ACT_B] = 1'b0;
               ret_d      = 1'b1;
               irqc_d     = tok_in[IOC_B];
            end
         end else if (result[RES_XACT]) begin
            nxt[CERR_HI:CERR_LO] = ec_next;
            if (ec_exh) begin
               nxt[ACT_B]     = 1'b0;
               nxt[HALT_B]    = 1'b1;
               nxt[XACTERR_B] = 1'b1;
               irqe_d         = err_irq_en;
            end
         end else if (result[RES_BUF]) begin
            nxt[BUFERR_B] = 1'b1;
         end else if (result[RES_STALL] || result[RES_BABBLE]) begin
            nxt[ACT_B]  = 1'b0;
            nxt[HALT_B] = 1'b1;
            if (result[RES_BABBLE]) nxt[BABBLE_B] = 1'b1;
            irqe_d = err_irq_en;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok_out      <= '0;
         out_valid    <= 1'b0;
         retire       <= 1'b0;
         irq_complete <= 1'b0;
         irq_error    <= 1'b0;
      end else begin
         out_valid    <= upd_valid;
         retire       <= ret_d;
         irq_complete <= irqc_d;
         irq_error    <= irqe_d;
         if (upd_valid) tok_out <= nxt;
      end
   end

   assign active_out = tok_out[ACT_B];
   assign halted_out = tok_out[HALT_B];
endmodule

// File: rtl/td_token_update_chk.sv
module td_token_update_chk
   import td_tok_pkg::*;
#(
   parameter int MAX_BYTES = 20480,
   parameter int MAX_PAGE  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             upd_valid,
   input logic [TOK_W-1:0] tok_in,
   input logic [RES_W-1:0] result,
   input logic             err_irq_en,
   input logic [TOK_W-1:0] tok_out,
   input logic             out_valid,
   input logic             active_out,
   input logic             halted_out,
   input logic             retire,
   input logic             irq_complete,
   input logic             irq_error
);
   // R1: input contract, a single result bit per update
   p_result_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $countones(result) == 1);

   // R1: output presented one cycle after request
   p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> out_valid);

   // R12: input contract on byte and page limits
   p_field_limits_r12: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (int'(tok_in[BYTES_HI:BYTES_LO]) <= MAX_BYTES)
                    && (int'(tok_in[PAGE_HI:PAGE_LO]) <= MAX_PAGE));

   // R12: page index untouched
   p_page_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> tok_out[PAGE_HI:PAGE_LO] == $past(tok_in[PAGE_HI:PAGE_LO]));

   // R2: byte count only moves on success
   p_bytes_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !result[RES_OK]) |=>
         tok_out[BYTES_HI:BYTES_LO] == $past(tok_in[BYTES_HI:BYTES_LO]));

   // R9: counter only moves on transaction errors
   p_cerr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !result[RES_XACT]) |=>
         tok_out[CERR_HI:CERR_LO] == $past(tok_in[CERR_HI:CERR_LO]));

   // R10: stall and babble halt immediately
   p_stall_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && tok_in[ACT_B] && (result[RES_STALL] || result[RES_BABBLE]))
         |=> halted_out && !active_out);

   // R3: a retired descriptor is inactive and not halted
   p_retire_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> !active_out && !halted_out);

   // R5: completion interrupt only with a retire
   p_irqc_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_complete |-> retire);

   // R7: error interrupt gated by enable
   p_irqe_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_error |-> $past(err_irq_en) && halted_out);

   // R11: inactive token passes through with no strobes
   p_inactive_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !tok_in[ACT_B]) |=>
         (tok_out == $past(tok_in)) && !retire && !irq_complete && !irq_error);
endmodule

bind td_token_update td_token_update_chk #(
   .MAX_BYTES(MAX_BYTES),
   .MAX_PAGE (MAX_PAGE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd_valid   (upd_valid),
   .tok_in      (tok_in),
   .result      (result),
   .err_irq_en  (err_irq_en),
   .tok_out     (tok_out),
   .out_valid   (out_valid),
   .active_out  (active_out),
   .halted_out  (halted_out),
   .retire      (retire),
   .irq_complete(irq_complete),
   .irq_error   (irq_error)
);

// File: tb/td_token_update_test.sv
module td_token_update_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [31:0] tok_in = '0;
   logic [4:0]  result = 5'b00001;
   logic [14:0] bytes_moved = '0;
   logic [10:0] max_pkt = 11'd64;
   logic        toggle_from_td = 1'b0;
   logic        err_irq_en = 1'b0;
   logic [31:0] tok_out;
   logic        out_valid, active_out, halted_out, retire, irq_complete, irq_error;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   localparam logic [4:0] OK = 5'b00001, XACT = 5'b00010, BUF = 5'b00100,
                          STALL = 5'b01000, BABBLE = 5'b10000;

   always #(CLK_PERIOD/2) clk = ~clk;

   td_token_update uut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .tok_in(tok_in),
      .result(result), .bytes_moved(bytes_moved), .max_pkt(max_pkt),
      .toggle_from_td(toggle_from_td), .err_irq_en(err_irq_en),
      .tok_out(tok_out), .out_valid(out_valid), .active_out(active_out),
      .halted_out(halted_out), .retire(retire), .irq_complete(irq_complete),
      .irq_error(irq_error)
   );

   function automatic logic [31:0] mk(input logic tgl, input logic [14:0] n,
                                      input logic ioc, input logic [2:0] pg,
                                      input logic [1:0] ce, input logic act);
      logic [31:0] t;
      t = '0;
      t[31] = tgl; t[30:16] = n; t[15] = ioc; t[14:12] = pg; t[11:10] = ce;
      t[9:8] = 2'b10; t[7] = act; t[1:0] = 2'b01;
      return t;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] t, input logic [4:0] r,
                        input logic [14:0] mv, input logic dtc, input logic en);
      @(negedge clk);
      tok_in = t; result = r; bytes_moved = mv;
      toggle_from_td = dtc; err_irq_en = en; upd_valid = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   function automatic logic [2:0] strobes();
      return {retire, irq_complete, irq_error};
   endfunction

   task automatic t_reset();
      chk("R1", "reset token", tok_out, '0);
      chk("R1", "reset strobes", {29'd0, out_valid, retire, irq_error}, '0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      tok_in = mk(0, 15'h100, 0, 3'd1, 2'd3, 1); result = BUF; upd_valid = 1'b1;
      chk("R1", "valid before edge", {31'd0, out_valid}, 32'd0);
      @(posedge clk); #1;
      chk("R1", "valid after edge", {31'd0, out_valid}, 32'd1);
      @(negedge clk); upd_valid = 1'b0;
      @(posedge clk); #1;
      chk("R1", "valid drops", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_partial();
      logic [31:0] t, e;
      t = mk(0, 15'h200, 1, 3'd2, 2'd3, 1);
      apply(t, OK, 15'h40, 1, 0);
      e = t; e[30:16] = 15'h1C0; e[31] = 1'b1;
      chk("R2", "partial count and R4 toggle", tok_out, e);
      chk("R3", "partial not retired", {29'd0, strobes()}, '0);
      t = mk(1, 15'h200, 0, 3'd0, 2'd3, 1);
      apply(t, OK, 15'h40, 0, 0);
      chk("R4", "toggle kept without descriptor control", {31'd0, tok_out[31]}, 32'd1);
   endtask

   task automatic t_last();
      logic [31:0] t, e;
      t = mk(0, 15'h40, 1, 3'd4, 2'd2, 1);
      apply(t, OK, 15'h40, 1, 0);
      e = t; e[30:16] = '0; e[31] = 1'b1; e[7] = 1'b0;
      chk("R3", "exact final token", tok_out, e);
      chk("R5", "retire with completion irq", {29'd0, strobes()}, 32'b110);
      chk("R12", "page 4 kept", {29'd0, tok_out[14:12]}, 32'd4);
   endtask

   task automatic t_short();
      logic [31:0] t, e;
      t = mk(0, 15'h200, 0, 3'd1, 2'd3, 1);
      apply(t, OK, 15'h10, 0, 0);
      e = t; e[30:16] = 15'h1F0; e[7] = 1'b0;
      chk("R3", "short packet retires", tok_out, e);
      chk("R5", "no irq without ioc", {29'd0, strobes()}, 32'b100);
   endtask

   task automatic t_zero_len();
      logic [31:0] t, e;
      t = mk(0, 15'h0, 1, 3'd0, 2'd1, 1);
      apply(t, OK, 15'h0, 0, 0);
      e = t; e[7] = 1'b0;
      chk("R3", "zero-length retires", tok_out, e);
      chk("R5", "zero-length completion irq", {29'd0, strobes()}, 32'b110);
   endtask

   task automatic t_xact();
      logic [31:0] t, e;
      t = mk(1, 15'h80, 1, 3'd3, 2'd3, 1);
      apply(t, XACT, 15'h20, 1, 1);
      e = t; e[11:10] = 2'd2;
      chk("R6", "counter decrements, stays active", tok_out, e);
      chk("R6", "no strobes", {29'd0, strobes()}, '0);
      t = mk(0, 15'h80, 0, 3'd0, 2'd1, 1);
      apply(t, XACT, 15'h0, 0, 1);
      e = t; e[11:10] = 2'd0; e[7] = 1'b0; e[6] = 1'b1; e[3] = 1'b1;
      chk("R7", "exhausted halts", tok_out, e);
      chk("R7", "error irq enabled", {29'd0, strobes()}, 32'b001);
      apply(t, XACT, 15'h0, 0, 0);
      chk("R7", "error irq disabled", {29'd0, strobes()}, '0);
      chk("R7", "halted without irq", {31'd0, halted_out}, 32'd1);
      t = mk(0, 15'h80, 0, 3'd0, 2'd0, 1);
      apply(t, XACT, 15'h0, 0, 1);
      chk("R8", "unlimited retries", tok_out, t);
      chk("R8", "no strobes", {29'd0, strobes()}, '0);
   endtask

   task automatic t_buf();
      logic [31:0] t, e;
      t = mk(0, 15'h80, 0, 3'd2, 2'd2, 1);
      apply(t, BUF, 15'h10, 1, 1);
      e = t; e[5] = 1'b1;
      chk("R9", "buffer error flagged only", tok_out, e);
      chk("R9", "no strobes", {29'd0, strobes()}, '0);
   endtask

   task automatic t_stall_babble();
      logic [31:0] t, e;
      t = mk(1, 15'h80, 0, 3'd1, 2'd2, 1);
      apply(t, STALL, 15'h0, 1, 1);
      e = t; e[7] = 1'b0; e[6] = 1'b1;
      chk("R10", "stall halts, counter kept", tok_out, e);
      chk("R10", "stall irq", {29'd0, strobes()}, 32'b001);
      apply(t, BABBLE, 15'h0, 1, 0);
      e[4] = 1'b1;
      chk("R10", "babble halts with flag", tok_out, e);
      chk("R10", "babble irq disabled", {29'd0, strobes()}, '0);
   endtask

   task automatic t_inactive();
      logic [31:0] t;
      t = mk(0, 15'h40, 1, 3'd2, 2'd1, 0);
      apply(t, OK, 15'h40, 1, 1);
      chk("R11", "inactive success passes", tok_out, t);
      chk("R11", "inactive success strobes", {29'd0, strobes()}, '0);
      apply(t, XACT, 15'h0, 1, 1);
      chk("R11", "inactive error passes", tok_out, t);
      chk("R11", "inactive error strobes", {29'd0, strobes()}, '0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 3 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_latency();
      t_partial();
      t_last();
      t_short();
      t_zero_len();
      t_xact();
      t_buf();
      t_stall_babble();
      t_inactive();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule